// File: doc/BRIEF.md
# Double-Buffered Receive Message Store

This block sits between a bit-level serial receiver and the CPU of a body-network node. The receiver hands it one byte at a time and then a single end-of-frame pulse, which carries a flag for any symbol-level fault. The block writes the incoming bytes into one of two equal message buffers. It runs a CRC-8 over the whole frame, including the trailing check byte, and decides at end of frame whether to keep the frame.

A frame that is kept flips the buffers. The buffer just filled becomes the one the CPU reads, through a single fixed address window, and the other buffer takes the next frame. The block latches the number of data bytes (the check byte is not counted and not readable) and raises a done flag, and an interrupt when enabled. A faulty frame leaves nothing behind. The CPU frees its buffer by pulsing the clear input. A good frame that arrives while the CPU still holds its buffer is thrown away, and an overrun flag is set.

Top module: `rx_pingpong_buf`

## Requirements
- R1: After reset, done_o, overrun_o, irq_o and rx_count_o are 0, and rd_data_o reads 0 at every address.
- R2: A frame of N data bytes (1 <= N <= MAX_BYTES) followed by its check byte and an error-free end-of-frame commits the frame. On the edge that samples rx_eof_i, done_o becomes 1 and rx_count_o becomes N, and addresses 0..N-1 read the data bytes in arrival order. The check byte is the bitwise inverse of a CRC-8 with polynomial 0x1D and initial value 0xFF, shifted MSB first. A frame passes when the residue over all received bytes is 0xC4.
- R3: A frame whose CRC residue is not 0xC4 is discarded. done_o, rx_count_o and the readable contents do not change.
- R4: A frame whose end-of-frame pulse carries rx_err_i=1 is discarded, even if its CRC is correct.
- R5: A frame with more than MAX_BYTES data bytes, or with only a check byte and no data byte, is discarded.
- R6: rd_data_o is 0 while done_o is 0, and at any address >= rx_count_o.
- R7: irq_o is 1 exactly when done_o and irq_en_i are both 1.
- R8: A pulse on done_clr_i clears done_o and overrun_o. Bytes received while the CPU holds a buffer never change what that buffer reads back.
- R9: A good frame that ends while done_o is 1 and done_clr_i is 0 is dropped. overrun_o becomes 1, and rx_count_o and the readable data stay as they were.
- R10: When done_clr_i and the end-of-frame pulse of a good frame fall in the same cycle, the new frame is committed: done_o stays 1 and rx_count_o shows the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | One received byte on rx_byte_i this cycle |
| rx_byte_i | input | 8 | Received byte |
| rx_eof_i | input | 1 | End-of-frame pulse, in a cycle without a byte |
| rx_err_i | input | 1 | Symbol-level fault seen in the frame, qualified by rx_eof_i |
| irq_en_i | input | 1 | Interrupt enable |
| done_clr_i | input | 1 | Write-one-to-clear pulse that releases the readable buffer |
| rd_addr_i | input | CW | Byte address in the read window |
| rd_data_o | output | 8 | Byte at rd_addr_i in the readable buffer |
| rx_count_o | output | CW | Data byte count of the readable message |
| done_o | output | 1 | A committed message is readable |
| overrun_o | output | 1 | A good frame was dropped because the buffer was still held |
| irq_o | output | 1 | Receive interrupt |

## Verification
The bench uses the default of 11 buffer bytes (CW=4). At this size it can send every legal data length from 1 to 11, and the lengths just outside it: a frame with no data byte and a frame with 12 data bytes. After each frame it reads all 16 window addresses, so it also sees the addresses above 11 that do not exist in the buffer. Each length is also sent with a corrupted check byte. Further cases cover the overrun, the hold-during-reception case and a release that coincides with a commit, all with the buffer index alternating.

// File: rtl/rxpp_pkg.sv
package rxpp_pkg;
  localparam logic [7:0] CRC_INIT = 8'hFF;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_GOOD = 8'hC4;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] data);
    logic [7:0] c;
    c = crc ^ data;
    for (int i = 0; i < 8; i++) begin
      c = c[7] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rx_crc8.sv
module rx_crc8 (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic [7:0] crc_o
);
  import rxpp_pkg::*;

  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_INIT;
    else if (clr_i) crc_q <= CRC_INIT;
    else if (en_i)  crc_q <= crc8_step(crc_q, data_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rx_frame_ctl.sv
module rx_frame_ctl #(
  parameter int MAX_BYTES = 11,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          byte_valid_i,
  input  logic [7:0]    byte_i,
  input  logic          eof_i,
  input  logic          err_i,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_idx_o,
  output logic          frame_good_o,
  output logic [CW-1:0] data_len_o
);
  import rxpp_pkg::*;

  localparam int CNTW = $clog2(MAX_BYTES + 3);
  localparam logic [CNTW-1:0] SAT     = CNTW'(MAX_BYTES + 2);
  localparam logic [CNTW-1:0] MAX_TOT = CNTW'(MAX_BYTES + 1);
  localparam logic [CNTW-1:0] MAX_DAT = CNTW'(MAX_BYTES);

  logic [CNTW-1:0] cnt_q;
  logic [7:0]      residue;

  rx_crc8 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (eof_i),
    .en_i   (byte_valid_i),
    .data_i (byte_i),
    .crc_o  (residue)
  );

  // saturating count of all bytes in the frame, check byte included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (eof_i)                       cnt_q <= '0;
    else if (byte_valid_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign wr_en_o      = byte_valid_i && (cnt_q < MAX_DAT);
  assign wr_idx_o     = cnt_q[CW-1:0];
  assign data_len_o   = CW'(cnt_q - 1'b1);
  assign frame_good_o = eof_i && !err_i && (cnt_q >= CNTW'(2)) &&
                        (cnt_q <= MAX_TOT) && (residue == CRC_GOOD);

  p_overlong_rejected_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && cnt_q > MAX_TOT) |-> !frame_good_o);
  p_short_rejected_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_i && cnt_q < CNTW'(2)) |-> !frame_good_o);
endmodule

// File: rtl/rx_bank.sv
module rx_bank #(
  parameter int MAX_BYTES = 11,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [CW-1:0] wr_idx_i,
  input  logic [7:0]    wr_data_i,
  input  logic          rd_en_i,
  input  logic          rd_sel_i,
  input  logic [CW-1:0] rd_len_i,
  input  logic [CW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem_q [MAX_BYTES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < MAX_BYTES; i++) mem_q[i] <= '0;
      end else if (wr_en_i && wr_sel_i == 1'(b)) begin
        mem_q[wr_idx_i] <= wr_data_i;
      end
    end

    always_comb begin
      bank_rd[b] = '0;
      if (rd_addr_i < CW'(MAX_BYTES)) bank_rd[b] = mem_q[rd_addr_i];
    end
  end

  assign rd_data_o = (rd_en_i && rd_addr_i < rd_len_i) ? bank_rd[rd_sel_i] : 8'h00;

  p_wr_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (wr_idx_i < CW'(MAX_BYTES)));
endmodule

// File: rtl/rx_pingpong_buf.sv
module rx_pingpong_buf #(
  parameter int MAX_BYTES = 11,
  parameter int CW        = $clog2(MAX_BYTES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_byte_i,
  input  logic          rx_eof_i,
  input  logic          rx_err_i,
  input  logic          irq_en_i,
  input  logic          done_clr_i,
  input  logic [CW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic          done_o,
  output logic          overrun_o,
  output logic          irq_o
);
  logic          fill_sel_q, done_q, ovr_q;
  logic [CW-1:0] len_q;
  logic          wr_en, frame_good, held, commit, drop;
  logic [CW-1:0] wr_idx, data_len;

  rx_frame_ctl #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_valid_i (rx_valid_i),
    .byte_i       (rx_byte_i),
    .eof_i        (rx_eof_i),
    .err_i        (rx_err_i),
    .wr_en_o      (wr_en),
    .wr_idx_o     (wr_idx),
    .frame_good_o (frame_good),
    .data_len_o   (data_len)
  );

  rx_bank #(.MAX_BYTES(MAX_BYTES), .CW(CW)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (fill_sel_q),
    .wr_idx_i  (wr_idx),
    .wr_data_i (rx_byte_i),
    .rd_en_i   (done_q),
    .rd_sel_i  (~fill_sel_q),
    .rd_len_i  (len_q),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  // a release in the same cycle frees the buffer for the frame ending now
  assign held   = done_q && !done_clr_i;
  assign commit = frame_good && !held;
  assign drop   = frame_good && held;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_sel_q <= 1'b0;
      done_q     <= 1'b0;
      len_q      <= '0;
    end else if (commit) begin
      fill_sel_q <= ~fill_sel_q;
      done_q     <= 1'b1;
      len_q      <= data_len;
    end else if (done_clr_i) begin
      done_q     <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ovr_q <= 1'b0;
    else if (drop)       ovr_q <= 1'b1;
    else if (done_clr_i) ovr_q <= 1'b0;
  end

  assign done_o     = done_q;
  assign overrun_o  = ovr_q;
  assign rx_count_o = len_q;
  assign irq_o      = done_q & irq_en_i;

  p_commit_sets_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_good |=> done_q);
  p_count_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (len_q >= CW'(1) && len_q <= CW'(MAX_BYTES)));
  p_bad_frame_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_eof_i && !frame_good && !done_clr_i) |=> ($stable(done_q) && $stable(len_q)));
  p_overrun_keeps_bank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_good && done_q && !done_clr_i) |=> (ovr_q && $stable(fill_sel_q) && $stable(len_q)));
  p_clr_releases_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_clr_i && !rx_eof_i) |=> (!done_q && !ovr_q));
endmodule

// File: tb/sim_rx_pingpong_buf.sv
module sim_rx_pingpong_buf;
  localparam int CLK_PERIOD = 10;
  localparam int MAXB = 11;
  localparam int CW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0]    rx_byte = '0;
  logic          irq_en = 1'b0, done_clr = 1'b0;
  logic [CW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic [CW-1:0] rx_count;
  logic          done, overrun, irq;

  int checks = 0, failures = 0;
  bit exp_done = 0, exp_ovr = 0;
  int exp_cnt = 0;
  logic [7:0] exp_data [MAXB];

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_pingpong_buf #(.MAX_BYTES(MAXB), .CW(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
    .rx_eof_i(rx_eof), .rx_err_i(rx_err), .irq_en_i(irq_en), .done_clr_i(done_clr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .rx_count_o(rx_count),
    .done_o(done), .overrun_o(overrun), .irq_o(irq)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_upd(logic [7:0] c, logic [7:0] d);
    c = c ^ d;
    for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] pat(int seed, int i);
    return 8'((seed * 37 + i * 13 + 5) & 255);
  endfunction

  // outputs checked mid-cycle, after the negedge that follows the updating edge
  task automatic check_state(string req);
    chk(req, "done", done, exp_done);
    chk(req, "overrun", overrun, exp_ovr);
    chk(req, "count", rx_count, exp_cnt);
    chk("R7", "irq", irq, exp_done && irq_en);
    for (int a = 0; a < 16; a++) begin
      rd_addr = CW'(a);
      #1;
      chk((exp_done && a < exp_cnt) ? req : "R6", "rd_data", rd_data,
          (exp_done && a < exp_cnt) ? exp_data[a] : 0);
    end
  endtask

  task automatic send_frame(int n, int seed, bit bad_crc, bit err, bit clr_at_eof);
    logic [7:0] c = 8'hFF;
    bit good;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = pat(seed, i);
      c = crc_upd(c, pat(seed, i));
    end
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = ~c ^ (bad_crc ? 8'h01 : 8'h00);
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b1; rx_err = err; done_clr = clr_at_eof;
    @(negedge clk);
    rx_eof = 1'b0; rx_err = 1'b0; done_clr = 1'b0;
    good = !bad_crc && !err && n >= 1 && n <= MAXB;
    if (good && exp_done && !clr_at_eof) exp_ovr = 1;
    else if (good) begin
      exp_done = 1; exp_cnt = n;
      for (int i = 0; i < n; i++) exp_data[i] = pat(seed, i);
      if (clr_at_eof) exp_ovr = 0;
    end else if (clr_at_eof) begin
      exp_done = 0; exp_ovr = 0;
    end
  endtask

  task automatic release_buf();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    exp_done = 0; exp_ovr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < MAXB; i++) exp_data[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1");
    irq_en = 1'b1;

    // R2 every legal length, R3 corrupted check byte at each length
    for (int n = 1; n <= MAXB; n++) begin
      send_frame(n, n + 3, 1, 0, 0);
      check_state("R3");
      send_frame(n, n, 0, 0, 0);
      check_state("R2");
      release_buf();
      check_state("R8");
    end

    // R4 symbol fault with a correct CRC
    send_frame(5, 40, 0, 1, 0);
    check_state("R4");
    // R5 too long and no data byte
    send_frame(MAXB + 1, 41, 0, 0, 0);
    check_state("R5");
    send_frame(0, 42, 0, 0, 0);
    check_state("R5");

    // R8 held buffer untouched by reception into the other one
    send_frame(7, 50, 0, 0, 0);
    check_state("R2");
    send_frame(MAXB, 51, 1, 0, 0);
    check_state("R8");
    // R9 good frame while held
    send_frame(3, 52, 0, 0, 0);
    check_state("R9");
    irq_en = 1'b0;
    #1;
    check_state("R7");
    irq_en = 1'b1;
    release_buf();
    check_state("R8");

    // R10 release coincides with a commit
    send_frame(4, 60, 0, 0, 0);
    check_state("R2");
    send_frame(9, 61, 0, 0, 1);
    check_state("R10");
    send_frame(2, 62, 0, 0, 1);
    check_state("R10");
    release_buf();
    check_state("R8");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule